// File: doc/BRIEF.md
# Paged Hardware-Monitor Register Window

This block gives a host a byte-wide window onto the register space of a hardware-monitor function. It answers a 256-byte I/O range: an 8-bit offset, 8-bit write data, a write strobe and a read strobe arrive from a bus front end that has already matched the base address. The paged area (offsets 0x10 to 0xFE) shows one of 16 pages. The page index register at offset 0xFF picks which page that is. Each page keeps its own bytes.

Updates come in batches, bracketed by bit 0 of the control register at offset 0x04. The host clears the bit to open a batch, writes its monitor registers, and sets the bit again to close the batch. When the batch closes, the block gives the internal monitor logic a one-cycle `data_changed` pulse. A small state machine runs the handshake. In `HW_LOCKED` (bit 0 reads 1, the state after reset), a write of bit 0 = 0 takes the transition *open* to `HW_OPEN`. In `HW_OPEN` (bit 0 reads 0), a write of bit 0 = 1 takes the transition *commit* to `HW_COMMIT`. `HW_COMMIT` lasts one cycle, reads bit 0 as 1 and raises the pulse. From there the transition *settle* leads to `HW_LOCKED`, or the transition *reopen* leads straight back to `HW_OPEN` if the host clears bit 0 during that cycle.

The byte at page 1, offset 0x98 is the fan duty value. It is brought out on its own port and drives a PWM output built on a free-running 8-bit counter.

Top module: `hwmon_window`

## Requirements
- R1: After reset, the control register reads 0x01, the page index reads 0x00, `data_changed` is 0, `fan_duty` is 0x00 and `fan_pwm` stays low.
- R2: A write of bit 0 = 0 to offset 0x04 opens a batch. Later writes to offsets 0x10 to 0xFE store their byte in the current page, and reading that offset on that page returns the byte.
- R3: While bit 0 of the control register is 1, writes to offsets 0x10 to 0xFE are ignored and the stored bytes, including `fan_duty`, stay unchanged.
- R4: A write that takes bit 0 from 0 to 1 makes `data_changed` high for exactly one cycle, the cycle after that write. A write of 1 while bit 0 is already 1 gives no pulse.
- R5: A write to offset 0xFF keeps only write-data bits 3:0 as the page number. Reading offset 0xFF returns the page number in bits 3:0 and zeros in bits 7:4.
- R6: A new page index applies from the very next access. The same offset on different pages holds independent bytes.
- R7: Offsets 0x00 to 0x03 and 0x05 to 0x0F read as 0x00, and writes to them change nothing.
- R8: Reads are allowed in any handshake state and have no side effect. `rdata` takes the addressed value at the clock edge where `rd_en` is high and holds it until the next read.
- R9: `fan_duty` always equals the byte at page 1, offset 0x98. It takes a new value at the edge of an accepted write to that location.
- R10: Over any 256 consecutive cycles, `fan_pwm` is high for exactly `fan_duty` cycles: 0x00 keeps it low, and 0xFF leaves one low cycle in each 256.
- R11: Only bit 0 of the control register is stored. Reading offset 0x04 returns that bit with bits 7:1 as zero, and the upper write-data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Offset within the 256-byte range |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| data_changed | output | 1 | One-cycle pulse when a batch closes |
| fan_duty | output | 8 | Page-1 offset-0x98 duty byte |
| fan_pwm | output | 1 | PWM output driven by the duty byte |

## Verification
Every result is due exactly one edge after its stimulus. Read data appears at the edge that samples `rd_en`. The `data_changed` pulse and the new `fan_duty` appear at the edge that takes the write. A new page index applies to an access made in the following cycle. The bench drives each strobe for one cycle starting at a falling edge and samples at the next falling edge, which lies just after the edge that registered the result. It then samples once more a cycle later to confirm that the pulse has dropped. PWM duty is measured by counting high samples over a full 256-cycle period, so the result does not depend on the counter's phase.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
    localparam int HW_ADDR_W    = 8;
    localparam int HW_DATA_W    = 8;
    localparam int HW_PAGE_W    = 4;
    localparam int HW_NUM_PAGES = 1 << HW_PAGE_W;

    localparam logic [7:0] HW_CTRL_OFS = 8'h04;
    localparam logic [7:0] HW_WIN_LO   = 8'h10;
    localparam logic [7:0] HW_WIN_HI   = 8'hFE;
    localparam logic [7:0] HW_PAGE_OFS = 8'hFF;
    localparam int         HW_WIN_BYTES = int'(HW_WIN_HI) - int'(HW_WIN_LO) + 1;

    localparam int         HW_DUTY_PAGE = 1;
    localparam logic [7:0] HW_DUTY_OFS  = 8'h98;

    typedef enum logic [1:0] {
        HW_LOCKED = 2'd0,
        HW_OPEN   = 2'd1,
        HW_COMMIT = 2'd2
    } hw_state_e;
endpackage

// File: rtl/hwmon_wr_fsm.sv
module hwmon_wr_fsm
    import hwmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic open,
    output logic data_changed
);
    hw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HW_LOCKED: if (ctrl_wr && !ctrl_bit) state_d = HW_OPEN;
            HW_OPEN:   if (ctrl_wr && ctrl_bit)  state_d = HW_COMMIT;
            HW_COMMIT: state_d = (ctrl_wr && !ctrl_bit) ? HW_OPEN : HW_LOCKED;
            default:   state_d = HW_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HW_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        open         = (state_q == HW_OPEN);
        data_changed = (state_q == HW_COMMIT);
    end

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_changed |=> !data_changed);

    // R4
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_changed) |-> $past(open && ctrl_wr && ctrl_bit));

    // R2
    open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(ctrl_wr && !ctrl_bit));
endmodule

// File: rtl/hwmon_page_store.sv
module hwmon_page_store
    import hwmon_pkg::*;
#(
    parameter int DATA_W    = HW_DATA_W,
    parameter int PAGE_W    = HW_PAGE_W,
    parameter int WIN_BYTES = HW_WIN_BYTES,
    parameter int DUTY_PAGE = HW_DUTY_PAGE,
    parameter int DUTY_IDX  = int'(HW_DUTY_OFS) - int'(HW_WIN_LO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] page,
    input  logic [7:0]        win_ofs,
    input  logic              win_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] duty
);
    localparam int DEPTH = (1 << PAGE_W) * WIN_BYTES;
    localparam int IDX_W = $clog2(DEPTH + 256);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] duty_q;
    logic [IDX_W-1:0]  idx;
    logic              duty_hit;

    always_comb begin
        idx      = IDX_W'(page) * IDX_W'(WIN_BYTES) + IDX_W'(win_ofs);
        duty_hit = (page == PAGE_W'(DUTY_PAGE)) && (win_ofs == 8'(DUTY_IDX));
    end

    always_ff @(posedge clk) begin
        if (win_wr && !duty_hit && (idx < IDX_W'(DEPTH))) mem[idx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 duty_q <= '0;
        else if (win_wr && duty_hit) duty_q <= wdata;
    end

    always_comb begin
        if (duty_hit)                    rd_data = duty_q;
        else if (idx < IDX_W'(DEPTH))    rd_data = mem[idx];
        else                             rd_data = '0;
        duty = duty_q;
    end
endmodule

// File: rtl/hwmon_fan_pwm.sv
module hwmon_fan_pwm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb pwm = (cnt_q < duty);

    // R10
    pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !pwm);
endmodule

// File: rtl/hwmon_window.sv
module hwmon_window
    import hwmon_pkg::*;
#(
    parameter int DATA_W = HW_DATA_W,
    parameter int PAGE_W = HW_PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              data_changed,
    output logic [DATA_W-1:0] fan_duty,
    output logic              fan_pwm
);
    localparam int PAD_W = DATA_W - PAGE_W;

    logic              is_ctrl, is_page, is_win, open, win_wr;
    logic [7:0]        win_ofs;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] store_rd, rd_mux, rdata_q;

    always_comb begin
        is_ctrl = (addr == HW_CTRL_OFS);
        is_page = (addr == HW_PAGE_OFS);
        is_win  = (addr >= HW_WIN_LO) && (addr <= HW_WIN_HI);
        win_ofs = addr - HW_WIN_LO;
        win_wr  = wr_en && is_win && open;
    end

    hwmon_wr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (wr_en && is_ctrl),
        .ctrl_bit     (wdata[0]),
        .open         (open),
        .data_changed (data_changed)
    );

    hwmon_page_store #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .page    (page_q),
        .win_ofs (win_ofs),
        .win_wr  (win_wr),
        .wdata   (wdata),
        .rd_data (store_rd),
        .duty    (fan_duty)
    );

    hwmon_fan_pwm #(.CNT_W(DATA_W)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .duty  (fan_duty),
        .pwm   (fan_pwm)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                page_q <= '0;
        else if (wr_en && is_page) page_q <= wdata[PAGE_W-1:0];
    end

    always_comb begin
        if (is_ctrl)      rd_mux = {{(DATA_W-1){1'b0}}, !open};
        else if (is_page) rd_mux = {{PAD_W{1'b0}}, page_q};
        else if (is_win)  rd_mux = store_rd;
        else              rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_en)  rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_ctrl && !is_page && !is_win) |=> (rdata == '0));

    // R5
    page_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_page) |=> (rdata[DATA_W-1:PAGE_W] == '0));

    // R3
    locked_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_win && !open) |=> $stable(fan_duty));

    // R9
    duty_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && open && addr == HW_DUTY_OFS && page_q == PAGE_W'(HW_DUTY_PAGE))
        |=> (fan_duty == $past(wdata)));
endmodule

// File: tb/hwmon_window_tb.sv
module hwmon_window_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata, fan_duty;
    logic       data_changed, fan_pwm;

    int total = 0, bad = 0;
    logic [7:0] mdl [16][256];
    bit         known [16][256];
    bit         m_open = 1'b0;
    logic [3:0] m_pg = '0;

    always #2 clk = ~clk;

    hwmon_window u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .data_changed(data_changed), .fan_duty(fan_duty), .fan_pwm(fan_pwm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [7:0] a);
        return (a >= 8'h10) && (a <= 8'hFE);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h04) return {7'b0, !m_open};
        if (a == 8'hFF) return {4'b0, m_pg};
        if (in_win(a))  return mdl[m_pg][a];
        return 8'h00;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h04) m_open = !d[0];
        if (a == 8'hFF) m_pg = d[3:0];
        if (in_win(a) && m_open) begin
            mdl[m_pg][a] = d;
            known[m_pg][a] = 1'b1;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic close_batch(input string req);
        wr(8'h04, 8'h01);
        chk(req, data_changed, 1);
        @(negedge clk);
        chk(req, data_changed, 0);
    endtask

    task automatic pwm_measure(input string req);
        int highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (fan_pwm) highs++;
        end
        chk(req, highs, fan_duty);
        chk(req, fan_duty, mdl[1][8'h98]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        for (int p = 0; p < 16; p++)
            for (int a = 0; a < 256; a++) begin
                mdl[p][a] = 8'h00;
                known[p][a] = 1'b0;
            end
        known[1][8'h98] = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 data_changed", data_changed, 0);
        chk("R1 fan_duty", fan_duty, 0);
        rd(8'h04, d); chk("R1 ctrl", d, 8'h01);
        rd(8'hFF, d); chk("R1 page", d, 8'h00);
        pwm_measure("R1 pwm low");

        // R11 only bit 0 kept
        wr(8'h04, 8'hFE);
        chk("R11 no pulse on open", data_changed, 0);
        rd(8'h04, d); chk("R11 ctrl open", d, 8'h00);
        close_batch("R4 pulse after close");
        rd(8'h04, d); chk("R11 ctrl locked", d, 8'h01);

        // R4 writing 1 while locked: no pulse
        wr(8'h04, 8'h01);
        chk("R4 no pulse when locked", data_changed, 0);

        // R3 writes ignored while locked
        wr(8'hFF, 8'h01);
        wr(8'h98, 8'h55);
        chk("R3 duty held", fan_duty, 0);
        rd(8'h98, d); chk("R3 locked write", d, 8'h00);

        // R5 upper page bits dropped
        wr(8'hFF, 8'hA3);
        rd(8'hFF, d); chk("R5 page readback", d, 8'h03);

        // R2 / R6 independent pages, switch applies at once
        wr(8'h04, 8'h00);
        wr(8'hFF, 8'h02); wr(8'h20, 8'h11);
        wr(8'hFF, 8'h03); wr(8'h20, 8'h22);
        rd(8'h20, d); chk("R2 readback page3", d, 8'h22);
        wr(8'hFF, 8'h02);
        rd(8'h20, d); chk("R6 page switch", d, 8'h11);
        wr(8'h10, 8'h5A);
        rd(8'h10, d); chk("R2 low edge of window", d, 8'h5A);
        wr(8'hFE, 8'hA5);
        rd(8'hFE, d); chk("R2 high edge of window", d, 8'hA5);

        // R7 unmapped offsets
        for (int a = 0; a < 16; a++) begin
            if (a != 4) begin
                wr(8'(a), 8'hC3);
                rd(8'(a), d); chk("R7 unmapped", d, 8'h00);
            end
        end
        rd(8'h04, d); chk("R7 ctrl untouched", d, 8'h00);

        // R9 / R10 duty byte
        wr(8'hFF, 8'h01);
        wr(8'h98, 8'h80);
        chk("R9 duty follows", fan_duty, 8'h80);
        pwm_measure("R10 half duty");
        wr(8'h98, 8'hFF);
        pwm_measure("R10 full duty");
        wr(8'h98, 8'h00);
        pwm_measure("R10 zero duty");
        close_batch("R4 second close");

        // R8 random traffic in both states
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            logic [7:0] a = 8'($urandom_range(0, 255));
            logic [7:0] v = 8'($urandom_range(0, 255));
            if (op < 4) wr(a, v);
            else if (op == 4) wr(8'hFF, v);
            else if (op == 5) begin
                if (m_open) close_batch("R4 random close");
                else begin
                    wr(8'h04, 8'h00);
                    chk("R4 no pulse on open", data_changed, 0);
                end
            end else begin
                rd(a, d);
                if (!in_win(a) || known[m_pg][a])
                    chk("R8 random read", d, exp_rd(a));
            end
            chk("R9 duty tracks model", fan_duty, mdl[1][8'h98]);
        end
        pwm_measure("R10 random duty");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule